// File: doc/BRIEF.md
# Eight-Point Inverse DCT Bus Accelerator

This block is a passive slave on an AHB-style bus that computes a one-dimensional, eight-point inverse discrete cosine transform on 16-bit signed samples. Software stores eight input coefficients as four 32-bit words, with two samples in each word. It then writes a control word that sets a start bit and picks row or column scaling. It polls the start bit until the hardware clears it, and then reads eight results, packed the same way, from four output words.

The block never starts a transfer of its own and never stretches one. Every access completes in the data phase right after its single-cycle address phase. The arithmetic takes two registered stages. The first stage forms all 64 coefficient products. The second stage reduces each row of products through a three-level adder tree, then rounds, shifts and saturates the sum into the result registers. A software loop runs the block over rows and then over columns to build a two-dimensional transform.

Top module: `idct8_accel`

## Requirements
- R1: After reset, every input word, every output word and the control word read as zero. The ready output is high and the response is OKAY.
- R2: Each 32-bit input or output word m holds element 2m in bits 31:16 and element 2m+1 in bits 15:0. Both are two's-complement 16-bit values.
- R3: Word offsets 0x00, 0x04, 0x08 and 0x0C are the input words, which can be read and written. Offset 0x10 is the control word. Offsets 0x20, 0x24, 0x28 and 0x2C are the output words, which are read-only, so writes to them change nothing. Any other offset reads as zero. In the control word, bits 31:2 read as zero.
- R4: In the control word, bit 0 is start/busy and bit 1 is the mode, where 0 means row and 1 means column. Writing a 1 to bit 0 sets busy on the clock edge that takes the write data. Busy stays set for exactly two more clock cycles and clears on the edge that loads the results. Bit 1 is stored on every accepted control write.
- R5: Before scaling, output k is the sum over n of W(k,n)·y(n). W(k,0) = 5793. For n > 0, W(k,n) = round(8192·cos((2k+1)·n·π/16)).
- R6: The sum is rounded by adding half of one result step, then shifted right arithmetically. Row mode shifts by 11 and column mode shifts by 18. The result then saturates to the range −32768 to 32767.
- R7: While busy is set, writes to the input words and to the control word are ignored, including writes to their mode and start bits.
- R8: The output words change only when a computation completes. They hold their values through later input writes until the next completion.
- R9: A transfer with an IDLE or BUSY type, a size other than 32 bits, or an address not aligned to a word has no effect and reads as zero.
- R10: The ready output is high and the response is OKAY in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address, address phase |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hwrite | input | 1 | High for a write |
| hsize | input | 3 | Transfer size (3'b010 = 32 bits) |
| hwdata | input | 32 | Write data, data phase |
| hready_in | input | 1 | Bus-wide ready; an address phase is taken only when high |
| hrdata | output | 32 | Read data, data phase |
| hreadyout | output | 1 | Slave ready, always high |
| hresp | output | 2 | Response, always OKAY (2'b00) |

## Verification
The bench builds the block with its default parameters: an 8-bit address and shifts of 11 for row mode and 18 for column mode. With these values, full-scale inputs drive the row-mode sum far beyond 16 bits, which exercises saturation at both rails. The same inputs in column mode stay in range, so the two scalings are tested against each other on identical data. Random sample sets in both modes are mixed with directed cases. These cases cover writes that fall inside the two-cycle busy window, and transfers whose type, size or alignment should make them have no effect.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int SAMP_W = 16;
    localparam int NPT    = 8;
    localparam int NWORD  = NPT / 2;
    localparam int WORD_W = 2 * SAMP_W;
    localparam int COEF_W = 16;
    localparam int PROD_W = SAMP_W + COEF_W;
    localparam int SUM_W  = PROD_W + $clog2(NPT) + 1;

    localparam logic [2:0] SIZE_WORD = 3'b010;
    localparam logic [1:0] RESP_OKAY = 2'b00;

    // cosine of idx*pi/16 in Q13
    function automatic logic signed [COEF_W-1:0] cos_q13(input int idx);
        int r;
        logic neg;
        logic signed [COEF_W-1:0] v;
        r   = idx % 32;
        neg = 1'b0;
        if (r > 16) r = 32 - r;
        if (r > 8) begin
            r   = 16 - r;
            neg = 1'b1;
        end
        case (r)
            0:       v = 16'sd8192;
            1:       v = 16'sd8035;
            2:       v = 16'sd7568;
            3:       v = 16'sd6811;
            4:       v = 16'sd5793;
            5:       v = 16'sd4551;
            6:       v = 16'sd3135;
            7:       v = 16'sd1598;
            default: v = 16'sd0;
        endcase
        return neg ? -v : v;
    endfunction

    // weight of input n in output k
    function automatic logic signed [COEF_W-1:0] coef(input int k, input int n);
        if (n == 0) return 16'sd5793;
        return cos_q13((2 * k + 1) * n);
    endfunction

endpackage

// File: rtl/idct8_addr_phase.sv
module idct8_addr_phase
    import idct8_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic              hready_in,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-3:0] word_idx
);

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-3:0] idx;
    } aph_t;

    aph_t ap_d, ap_q;

    always_comb begin
        logic take;
        take = hsel && hready_in && htrans[1] && (hsize == SIZE_WORD)
               && (haddr[1:0] == 2'b00);
        ap_d.wr  = take && hwrite;
        ap_d.rd  = take && !hwrite;
        ap_d.idx = haddr[ADDR_W-1:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ap_q <= '0;
        else        ap_q <= ap_d;
    end

    assign wr_en    = ap_q.wr;
    assign rd_en    = ap_q.rd;
    assign word_idx = ap_q.idx;

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_en}));

    // R9
    narrow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && htrans[1] && hsize != SIZE_WORD) |=> (!wr_en && !rd_en));

    // R9
    idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!htrans[1]) |=> (!wr_en && !rd_en));

endmodule

// File: rtl/idct8_mul_stage.sv
module idct8_mul_stage
    import idct8_pkg::*;
(
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    launch,
    input  logic [NPT-1:0][SAMP_W-1:0]              samp,
    output logic                                    prod_vld,
    output logic [NPT-1:0][NPT-1:0][PROD_W-1:0]     prod
);

    typedef struct packed {
        logic                                vld;
        logic [NPT-1:0][NPT-1:0][PROD_W-1:0] p;
    } mul_t;

    mul_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = launch;
        if (launch) begin
            for (int k = 0; k < NPT; k++) begin
                for (int n = 0; n < NPT; n++) begin
                    s_d.p[k][n] = $signed(samp[n]) * coef(k, n);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prod_vld = s_q.vld;
    assign prod     = s_q.p;

    // R4
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vld |=> !prod_vld);

endmodule

// File: rtl/idct8_sum_stage.sv
module idct8_sum_stage
    import idct8_pkg::*;
#(
    parameter int ROW_SHIFT = 11,
    parameter int COL_SHIFT = 18
) (
    input  logic [NPT-1:0][NPT-1:0][PROD_W-1:0] prod,
    input  logic                                mode,
    output logic [NPT-1:0][SAMP_W-1:0]          res
);

    localparam longint RND_ROW_L = longint'(1) << (ROW_SHIFT - 1);
    localparam longint RND_COL_L = longint'(1) << (COL_SHIFT - 1);
    localparam longint SAT_HI_L  = (longint'(1) << (SAMP_W - 1)) - 1;
    localparam logic signed [SUM_W-1:0] RND_ROW = SUM_W'(RND_ROW_L);
    localparam logic signed [SUM_W-1:0] RND_COL = SUM_W'(RND_COL_L);
    localparam logic signed [SUM_W-1:0] SAT_HI  = SUM_W'(SAT_HI_L);
    localparam logic signed [SUM_W-1:0] SAT_LO  = -SAT_HI - 1;
    localparam int HALF = NPT / 2;

    function automatic logic signed [SUM_W-1:0] sext(input logic [PROD_W-1:0] v);
        return {{(SUM_W - PROD_W){v[PROD_W-1]}}, v};
    endfunction

    for (genvar k = 0; k < NPT; k++) begin : g_out
        logic signed [SUM_W-1:0] lv1 [HALF];
        logic signed [SUM_W-1:0] lv2 [HALF/2];
        logic signed [SUM_W-1:0] tot;
        logic signed [SUM_W-1:0] shf;

        always_comb begin
            for (int j = 0; j < HALF; j++) begin
                lv1[j] = sext(prod[k][2*j]) + sext(prod[k][2*j+1]);
            end
            for (int j = 0; j < HALF / 2; j++) begin
                lv2[j] = lv1[2*j] + lv1[2*j+1];
            end
            tot = lv2[0] + lv2[1];
            if (mode) shf = (tot + RND_COL) >>> COL_SHIFT;
            else      shf = (tot + RND_ROW) >>> ROW_SHIFT;
            if (shf > SAT_HI)      res[k] = SAT_HI[SAMP_W-1:0];
            else if (shf < SAT_LO) res[k] = SAT_LO[SAMP_W-1:0];
            else                   res[k] = shf[SAMP_W-1:0];
        end
    end

endmodule

// File: rtl/idct8_accel.sv
module idct8_accel
    import idct8_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int ROW_SHIFT = 11,
    parameter int COL_SHIFT = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [31:0]       hwdata,
    input  logic              hready_in,
    output logic [31:0]       hrdata,
    output logic              hreadyout,
    output logic [1:0]        hresp
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam int SEL_LO = $clog2(NWORD);
    localparam logic [WIDX_W-1:0] W_IN0  = WIDX_W'(0);
    localparam logic [WIDX_W-1:0] W_CTRL = WIDX_W'(4);
    localparam logic [WIDX_W-1:0] W_OUT0 = WIDX_W'(8);

    typedef struct packed {
        logic [NWORD-1:0][WORD_W-1:0] in;
        logic [NWORD-1:0][WORD_W-1:0] res;
        logic                         busy;
        logic                         mode;
        logic                         go;
    } st_t;

    st_t st_d, st_q;

    logic                                wr_en, rd_en;
    logic [WIDX_W-1:0]                   word_idx;
    logic                                in_hit, ctrl_hit, out_hit;
    logic [SEL_LO-1:0]                   slot;
    logic [NPT-1:0][SAMP_W-1:0]          samp;
    logic                                prod_vld;
    logic [NPT-1:0][NPT-1:0][PROD_W-1:0] prod;
    logic [NPT-1:0][SAMP_W-1:0]          xres;
    logic [NWORD-1:0][WORD_W-1:0]        res_pk;

    idct8_addr_phase #(.ADDR_W(ADDR_W)) u_aph (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsel     (hsel),
        .haddr    (haddr),
        .htrans   (htrans),
        .hwrite   (hwrite),
        .hsize    (hsize),
        .hready_in(hready_in),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .word_idx (word_idx)
    );

    assign in_hit   = (word_idx >> SEL_LO) == (W_IN0 >> SEL_LO);
    assign out_hit  = (word_idx >> SEL_LO) == (W_OUT0 >> SEL_LO);
    assign ctrl_hit = (word_idx == W_CTRL);
    assign slot     = word_idx[SEL_LO-1:0];

    for (genvar m = 0; m < NWORD; m++) begin : g_pack
        assign samp[2*m]   = st_q.in[m][WORD_W-1:SAMP_W];
        assign samp[2*m+1] = st_q.in[m][SAMP_W-1:0];
        assign res_pk[m]   = {xres[2*m], xres[2*m+1]};
    end

    idct8_mul_stage u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (st_q.go),
        .samp    (samp),
        .prod_vld(prod_vld),
        .prod    (prod)
    );

    idct8_sum_stage #(.ROW_SHIFT(ROW_SHIFT), .COL_SHIFT(COL_SHIFT)) u_sum (
        .prod(prod),
        .mode(st_q.mode),
        .res (xres)
    );

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        if (wr_en && !st_q.busy) begin
            if (in_hit) begin
                st_d.in[slot] = hwdata;
            end else if (ctrl_hit) begin
                st_d.mode = hwdata[1];
                if (hwdata[0]) begin
                    st_d.busy = 1'b1;
                    st_d.go   = 1'b1;
                end
            end
        end
        if (prod_vld) begin
            st_d.res  = res_pk;
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        hrdata = '0;
        if (rd_en) begin
            if (in_hit)        hrdata = st_q.in[slot];
            else if (ctrl_hit) hrdata = {30'b0, st_q.mode, st_q.busy};
            else if (out_hit)  hrdata = st_q.res[slot];
        end
    end

    assign hreadyout = 1'b1;
    assign hresp     = RESP_OKAY;

    // R4
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_hit && hwdata[0] && !st_q.busy) |=> st_q.busy);

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |=> st_q.busy ##1 !st_q.busy);

    // R7
    in_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.in));

    // R7
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.mode));

    // R8
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> $stable(st_q.res));

    // R8
    res_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(prod_vld));

endmodule

// File: tb/idct8_accel_bench.sv
module idct8_accel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [7:0]  haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'b010;
    logic [31:0] hwdata = '0;
    logic        hready_in = 1'b1;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic [1:0]  hresp;

    int n_chk = 0;
    int n_bad = 0;
    int bus_viol = 0;
    bit finished = 1'b0;
    int yv [8];

    always #4 clk = ~clk;

    idct8_accel u_idct8_accel (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready_in(hready_in),
        .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
    );

    // R10 monitor
    always @(negedge clk) begin
        if (rst_n && (hreadyout !== 1'b1 || hresp !== 2'b00)) bus_viol++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [1:0] tr = 2'b10, input logic [2:0] sz = 3'b010);
        @(negedge clk);
        hsel = 1'b1; haddr = a; hwrite = 1'b1; htrans = tr; hsize = sz;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hsize = 3'b010; hwdata = d;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        hsel = 1'b1; haddr = a; hwrite = 1'b0; htrans = 2'b10; hsize = 3'b010;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        d = hrdata;
    endtask

    function automatic int coefm(int k, int n);
        real a;
        if (n == 0) a = 0.7071067811865476;
        else        a = $cos((2 * k + 1) * n * 3.141592653589793 / 16.0);
        return int'(a * 8192.0);
    endfunction

    function automatic int model_x(int k, bit md);
        longint acc;
        int sh;
        acc = 0;
        for (int n = 0; n < 8; n++) acc += longint'(yv[n]) * longint'(coefm(k, n));
        sh = md ? 18 : 11;
        acc = (acc + (longint'(1) << (sh - 1))) >>> sh;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    function automatic logic [31:0] pack2(int a, int b);
        logic [15:0] ha, hb;
        ha = a[15:0];
        hb = b[15:0];
        return {ha, hb};
    endfunction

    task automatic load_inputs();
        for (int m = 0; m < 4; m++) bus_write(8'(4 * m), pack2(yv[2*m], yv[2*m+1]));
    endtask

    task automatic check_outputs(input bit md, input string req);
        logic [31:0] d;
        for (int m = 0; m < 4; m++) begin
            bus_read(8'(8'h20 + 4 * m), d);
            chk(req, d, pack2(model_x(2*m, md), model_x(2*m+1, md)));
        end
    endtask

    task automatic run_xform(input bit md, input string req);
        logic [31:0] d;
        load_inputs();
        bus_write(8'h10, {30'b0, md, 1'b1});
        bus_read(8'h10, d);
        chk("R4 busy after start", d, {30'b0, md, 1'b1});
        bus_read(8'h10, d);
        chk("R4 busy cleared", d, {30'b0, md, 1'b0});
        check_outputs(md, req);
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] keep;
        void'($urandom(32'd20160204));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h10, d); chk("R1 ctrl", d, 32'h0);
        bus_read(8'h00, d); chk("R1 in0", d, 32'h0);
        bus_read(8'h2C, d); chk("R1 out3", d, 32'h0);

        // R5 DC input, row mode: every output (1000*5793+1024)>>11 = 2829
        yv = '{1000, 0, 0, 0, 0, 0, 0, 0};
        run_xform(1'b0, "R5 dc row");
        bus_read(8'h20, d); chk("R5 dc literal", d, {16'd2829, 16'd2829});

        // R2 lone odd element lands in bits 15:0
        yv = '{0, 1000, 0, 0, 0, 0, 0, 0};
        load_inputs();
        bus_read(8'h00, d); chk("R2 input packing", d, 32'h0000_03E8);
        run_xform(1'b1, "R2 odd element column");

        // R6 saturation at both rails in row mode, in range in column mode
        yv = '{32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767};
        run_xform(1'b0, "R6 sat high row");
        bus_read(8'h20, d); chk("R6 sat rail high", d[31:16], 32'h7FFF);
        run_xform(1'b1, "R6 full scale column");
        yv = '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768};
        run_xform(1'b0, "R6 sat low row");
        bus_read(8'h20, d); chk("R6 sat rail low", d[31:16], 32'h8000);

        // R7 input write inside busy window is dropped
        yv = '{100, -200, 300, -400, 500, -600, 700, -800};
        load_inputs();
        bus_write(8'h10, 32'h1);
        bus_write(8'h00, 32'hDEAD_BEEF);
        bus_read(8'h00, d); chk("R7 input frozen", d, pack2(100, -200));
        check_outputs(1'b0, "R7 result uses old inputs");

        // R7 control write inside busy window is dropped
        bus_write(8'h10, 32'h1);
        bus_write(8'h10, 32'h3);
        bus_read(8'h10, d); chk("R7 ctrl frozen", d, 32'h0);

        // R8 outputs hold across input writes without start
        bus_read(8'h24, keep);
        bus_write(8'h04, 32'h1234_5678);
        bus_write(8'h00, 32'h7FFF_8000);
        bus_read(8'h24, d); chk("R8 output hold", d, keep);
        load_inputs();

        // R3 map: outputs read-only, hole reads zero, ctrl spare bits zero
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_read(8'h24, d); chk("R3 output read-only", d, keep);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_read(8'h18, d); chk("R3 hole reads zero", d, 32'h0);
        bus_write(8'h10, 32'hFFFF_FFFE);
        bus_read(8'h10, d); chk("R3 ctrl spare bits", d, 32'h2);
        bus_write(8'h10, 32'h0);

        // R9 IDLE, BUSY-type, narrow and misaligned transfers do nothing
        bus_write(8'h04, 32'hAAAA_5555, 2'b00);
        bus_read(8'h04, d); chk("R9 idle write", d, pack2(yv[2], yv[3]));
        bus_write(8'h08, 32'hAAAA_5555, 2'b10, 3'b001);
        bus_read(8'h08, d); chk("R9 halfword write", d, pack2(yv[4], yv[5]));
        bus_write(8'h10, 32'h1, 2'b01);
        bus_read(8'h10, d); chk("R9 busy-type start", d, 32'h0);
        bus_write(8'h01, 32'hAAAA_5555);
        bus_read(8'h00, d); chk("R9 misaligned write", d, pack2(yv[0], yv[1]));

        // R5 R6 random sample sets, both modes
        for (int i = 0; i < 40; i++) begin
            for (int n = 0; n < 8; n++) begin
                logic [15:0] t;
                t = 16'($urandom);
                if (i % 3 == 0) t = {{6{t[9]}}, t[9:0]};
                yv[n] = int'($signed(t));
            end
            run_xform(i[0], i[0] ? "R6 random column" : "R5 random row");
        end

        // R10 ready/response seen every cycle
        chk("R10 ready and OKAY", 32'(bus_viol), 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule